// File: doc/BRIEF.md
# Hit Frame-Train Assembler

The assembler sits behind the sensor receivers of a triggerless pixel readout. Each sensor stream delivers 32-bit zero-suppressed hit words, grouped into superframes of 16 consecutive 50 ns frames. Each stream closes a superframe with an end marker. The block collects one superframe from all streams and bins every hit by its frame number. It then sends the hits out bucket by bucket, so the output is in ascending frame order within the slice. The per-superframe grouping is dropped. Consecutive superframes are concatenated into one long frame train for a single downstream processing node, and with the default setting a train covers 1024 frames.

A train goes out as one framed word stream that is striped across two output links. The train opens with a header word that carries the train number and closes with a trailer word that carries the hit count and drop statistics. Each frame bucket has a fixed depth. Hits that arrive at a full bucket are discarded and counted, and the trailer flags the loss.

Top module: `ftrain_asm`

## Requirements
- R1: After reset, both output links show no valid word, and no input is ready unless it presents a word.
- R2: Hit word layout is [31:24] frame timestamp, [23:20] sensor id, [19:0] pixel address, and the bucket is timestamp bits [27:24]. The hits of a superframe leave in ascending bucket order (0 to 15). Within a bucket they keep the order of acceptance.
- R3: At most one input word is accepted per cycle. When several streams are valid, the lowest-numbered stream wins. A stream that has sent its end marker (in_eos high with valid) is held not-ready until its superframe has been drained.
- R4: No output word is offered while inputs can still be accepted. Draining begins only once every stream has sent its end marker.
- R5: Each train begins with a header word, flagged by head, with the train number in bits [15:0] and zero in [31:16]. Train numbers count up from 0, and the header always travels on link 0.
- R6: After SF_PER_TRAIN superframes, a trailer word, flagged by tail, ends the train. Its layout is [31] drop flag, [30:16] dropped-hit count, [15:0] kept-hit count.
- R7: Words alternate between the links, starting on link 0 at each train. Only one link is valid at a time.
- R8: A bucket holds at most DEPTH hits per superframe. Further hits for that bucket are accepted and then discarded, each one raises the train's dropped count, and the trailer drop flag is set.
- R9: An offered output word stays valid and unchanged until its link accepts it.
- R10: The hit and drop counts restart at zero for every train.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_IN | Per-stream word valid |
| in_ready | output | NUM_IN | Per-stream word accepted |
| in_data | input | NUM_IN*32 | Per-stream hit words, stream i in bits [32i+31:32i] |
| in_eos | input | NUM_IN | Word is an end-of-superframe marker, not a hit |
| o0_valid | output | 1 | Link 0 word valid |
| o0_ready | input | 1 | Link 0 accepts |
| o0_data | output | 32 | Link 0 word |
| o0_head | output | 1 | Link 0 word is a train header |
| o0_tail | output | 1 | Link 0 word is a train trailer |
| o1_valid | output | 1 | Link 1 word valid |
| o1_ready | input | 1 | Link 1 accepts |
| o1_data | output | 32 | Link 1 word |
| o1_head | output | 1 | Link 1 word is a train header |
| o1_tail | output | 1 | Link 1 word is a train trailer |

## Verification
The assertions assume that the sources obey valid/ready: a stream does not withdraw or change a word before it is taken. They also assume that every stream eventually sends one end marker per superframe, since a stream that never closes would freeze the drain. The stimulus drives each word from a negative edge and holds it until the ready sampled before the next rising edge shows acceptance. It ends every stream's share of a superframe with exactly one marker, including when a stream has no hits. The link readies follow a pseudo-random pattern, so the hold checks see real stalls.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int HIT_W  = 32;
  localparam int TS_LSB = 24;

  typedef enum logic [1:0] {
    S_FILL = 2'd0,
    S_HDR  = 2'd1,
    S_HITS = 2'd2,
    S_TRL  = 2'd3
  } ft_state_t;

  function automatic logic [HIT_W-1:0] mk_header(input logic [15:0] train);
    return {16'h0000, train};
  endfunction

  function automatic logic [HIT_W-1:0] mk_trailer(input logic [14:0] drops,
                                                  input logic [15:0] hits);
    return {(drops != 15'd0), drops, hits};
  endfunction
endpackage

// File: rtl/frt_arb.sv
module frt_arb #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    gnt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) gnt = N'(1) << i;
    end
  end

  always_comb begin
    // R3
    grant_onehot_chk: assert ($onehot0(gnt));
    // R3
    grant_req_chk: assert ((gnt & ~req) == '0);
  end
endmodule

// File: rtl/frt_bins.sv
module frt_bins #(
  parameter int NB    = 16,
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [$clog2(NB)-1:0]  wr_bkt,
  input  logic [W-1:0]           wr_data,
  output logic                   wr_full,
  input  logic                   clr,
  input  logic [$clog2(NB)-1:0]  rd_bkt,
  input  logic [((DEPTH>1)?$clog2(DEPTH):1)-1:0] rd_idx,
  output logic [W-1:0]           rd_data,
  output logic [$clog2(DEPTH+1)-1:0] rd_cnt
);
  localparam int BW = $clog2(NB);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem     [NB][DEPTH];
  logic [CW-1:0] cnt     [NB];
  logic [CW-1:0] cnt_nxt [NB];
  logic          wr_ok;

  assign wr_full = (cnt[wr_bkt] == CW'(DEPTH));
  assign wr_ok   = wr_en && !wr_full;
  assign rd_data = mem[rd_bkt][rd_idx];
  assign rd_cnt  = cnt[rd_bkt];

  always_comb begin
    for (int b = 0; b < NB; b++) cnt_nxt[b] = cnt[b];
    if (clr) begin
      for (int b = 0; b < NB; b++) cnt_nxt[b] = '0;
    end else if (wr_ok) begin
      cnt_nxt[wr_bkt] = cnt[wr_bkt] + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) cnt[b] <= '0;
    end else begin
      for (int b = 0; b < NB; b++) cnt[b] <= cnt_nxt[b];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_bkt][cnt[wr_bkt][AW-1:0]] <= wr_data;
  end

  generate
    for (genvar g = 0; g < NB; g++) begin : g_cap
      // R8
      bkt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[g] <= CW'(DEPTH));
    end
  endgenerate

  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_full && !clr) |=> (cnt[$past(wr_bkt)] == CW'(DEPTH)));

  logic [BW-1:0] unused_bw;
  assign unused_bw = '0;
endmodule

// File: rtl/ftrain_asm.sv
module ftrain_asm #(
  parameter int NUM_IN       = 2,
  parameter int DEPTH        = 4,
  parameter int SF_PER_TRAIN = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_IN-1:0]     in_valid,
  output logic [NUM_IN-1:0]     in_ready,
  input  logic [NUM_IN*32-1:0]  in_data,
  input  logic [NUM_IN-1:0]     in_eos,
  output logic                  o0_valid,
  input  logic                  o0_ready,
  output logic [31:0]           o0_data,
  output logic                  o0_head,
  output logic                  o0_tail,
  output logic                  o1_valid,
  input  logic                  o1_ready,
  output logic [31:0]           o1_data,
  output logic                  o1_head,
  output logic                  o1_tail
);
  import frt_pkg::*;

  localparam int NB  = 16;
  localparam int BW  = $clog2(NB);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SW  = $clog2(SF_PER_TRAIN + 1);

  ft_state_t          st, st_n;
  logic [NUM_IN-1:0]  closed, closed_n;
  logic [BW-1:0]      bkt, bkt_n;
  logic [CW-1:0]      idx, idx_n;
  logic [SW-1:0]      sf_cnt, sfc_n;
  logic [15:0]        train_no, trn_n;
  logic [15:0]        hit_cnt, hits_n;
  logic [14:0]        drop_cnt, drops_n;
  logic               lnk, lnk_n;

  logic [NUM_IN-1:0]  req, gnt;
  logic [HIT_W-1:0]   sel_word;
  logic               sel_eos, wr_en, bkt_full, clr;
  logic [HIT_W-1:0]   rd_data, out_word;
  logic [CW-1:0]      rd_cnt;
  logic               out_vld, fire, hit_avail;

  assign req      = in_valid & ~closed & {NUM_IN{st == S_FILL}};
  assign in_ready = gnt;

  frt_arb #(.N(NUM_IN)) u_arb (.req(req), .gnt(gnt));

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      if (gnt[i]) sel_word = in_data[i*HIT_W +: HIT_W];
    end
  end
  assign sel_eos = |(gnt & in_eos);
  assign wr_en   = (|gnt) && !sel_eos;

  frt_bins #(.NB(NB), .DEPTH(DEPTH), .W(HIT_W)) u_bins (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_bkt(sel_word[TS_LSB +: BW]), .wr_data(sel_word),
    .wr_full(bkt_full), .clr(clr),
    .rd_bkt(bkt), .rd_idx(idx[AW-1:0]), .rd_data(rd_data), .rd_cnt(rd_cnt)
  );

  assign hit_avail = (idx < rd_cnt);
  assign out_vld   = (st == S_HDR) || (st == S_TRL) || ((st == S_HITS) && hit_avail);
  assign fire      = out_vld && (lnk ? o1_ready : o0_ready);

  always_comb begin
    unique case (st)
      S_HDR:   out_word = mk_header(train_no);
      S_TRL:   out_word = mk_trailer(drop_cnt, hit_cnt);
      default: out_word = rd_data;
    endcase
  end

  assign o0_valid = out_vld && !lnk;
  assign o1_valid = out_vld && lnk;
  assign o0_data  = out_word;
  assign o1_data  = out_word;
  assign o0_head  = (st == S_HDR);
  assign o1_head  = (st == S_HDR);
  assign o0_tail  = (st == S_TRL);
  assign o1_tail  = (st == S_TRL);

  always_comb begin
    st_n = st; closed_n = closed; bkt_n = bkt; idx_n = idx; sfc_n = sf_cnt;
    trn_n = train_no; hits_n = hit_cnt; drops_n = drop_cnt; lnk_n = lnk; clr = 1'b0;
    if (wr_en && !bkt_full) hits_n  = hit_cnt + 16'd1;
    if (wr_en && bkt_full)  drops_n = drop_cnt + 15'd1;
    if (fire) lnk_n = ~lnk;
    unique case (st)
      S_FILL: begin
        closed_n = closed | (gnt & in_eos);
        if (&closed_n) begin
          st_n  = (sf_cnt == '0) ? S_HDR : S_HITS;
          bkt_n = '0;
          idx_n = '0;
        end
      end
      S_HDR: if (fire) st_n = S_HITS;
      S_HITS: begin
        if (hit_avail) begin
          if (fire) idx_n = idx + CW'(1);
        end else begin
          idx_n = '0;
          if (bkt == BW'(NB - 1)) begin
            clr      = 1'b1;
            closed_n = '0;
            if (sf_cnt == SW'(SF_PER_TRAIN - 1)) begin
              st_n = S_TRL;
            end else begin
              sfc_n = sf_cnt + SW'(1);
              st_n  = S_FILL;
            end
          end else begin
            bkt_n = bkt + BW'(1);
          end
        end
      end
      S_TRL: if (fire) begin
        trn_n = train_no + 16'd1; sfc_n = '0; hits_n = '0; drops_n = '0;
        lnk_n = 1'b0; st_n = S_FILL;
      end
      default: st_n = S_FILL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_FILL; closed <= '0; bkt <= '0; idx <= '0; sf_cnt <= '0;
      train_no <= '0; hit_cnt <= '0; drop_cnt <= '0; lnk <= 1'b0;
    end else begin
      st <= st_n; closed <= closed_n; bkt <= bkt_n; idx <= idx_n; sf_cnt <= sfc_n;
      train_no <= trn_n; hit_cnt <= hits_n; drop_cnt <= drops_n; lnk <= lnk_n;
    end
  end

  // R7
  one_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(o0_valid && o1_valid));
  // R4
  fill_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|in_ready) |-> !(o0_valid || o1_valid));
  // R9
  hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o0_valid && !o0_ready) |=> (o0_valid && $stable(o0_data)));
  // R9
  hold1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o1_valid && !o1_ready) |=> (o1_valid && $stable(o1_data)));
  // R5
  head_link0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    o1_valid |-> !o1_head);

  generate
    for (genvar g = 0; g < NUM_IN; g++) begin : g_blk
      // R3
      closed_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        closed[g] |-> !in_ready[g]);
    end
  endgenerate
endmodule

// File: tb/sim_ftrain_asm.sv
module sim_ftrain_asm;
  localparam int NI = 2;
  localparam int DP = 4;
  localparam int SF = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [NI-1:0] iv, in_ready, ieos;
  logic [31:0] idat0, idat1;
  logic o0_valid, o0_ready, o0_head, o0_tail;
  logic o1_valid, o1_ready, o1_head, o1_tail;
  logic [31:0] o0_data, o1_data;

  always #10 clk = ~clk;

  ftrain_asm #(.NUM_IN(NI), .DEPTH(DP), .SF_PER_TRAIN(SF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(iv), .in_ready(in_ready),
    .in_data({idat1, idat0}), .in_eos(ieos),
    .o0_valid(o0_valid), .o0_ready(o0_ready), .o0_data(o0_data),
    .o0_head(o0_head), .o0_tail(o0_tail),
    .o1_valid(o1_valid), .o1_ready(o1_ready), .o1_data(o1_data),
    .o1_head(o1_head), .o1_tail(o1_tail));

  typedef struct { logic lk; logic hd; logic tl; logic [31:0] d; } exp_t;
  exp_t q[$];
  int checks = 0, failures = 0;
  int tr_words = 0, tr_hits = 0, tr_drops = 0, sf_in_tr = 0, tr_no = 0;
  logic mon_on = 1'b0;
  logic [7:0] lf = 8'hA5;

  function automatic logic [31:0] hw(input logic [7:0] ts, input logic [3:0] id,
                                     input logic [19:0] px);
    return {ts, id, px};
  endfunction

  task automatic add_exp(input logic [31:0] d, input logic hd, input logic tl);
    exp_t e;
    e.lk = tr_words[0]; e.hd = hd; e.tl = tl; e.d = d;
    q.push_back(e);
    tr_words++;
  endtask

  task automatic push(input int s, input logic [31:0] d, input logic e);
    @(negedge clk);
    iv[s] = 1'b1; ieos[s] = e;
    if (s == 0) idat0 = d; else idat1 = d;
    #1;
    while (!in_ready[s]) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic drive(input int s, input logic [31:0] w[$]);
    foreach (w[k]) push(s, w[k], 1'b0);
    push(s, 32'h0, 1'b1);
    @(negedge clk);
    iv[s] = 1'b0; ieos[s] = 1'b0;
  endtask

  // expected model: stream 0 wins arbitration (R3), so arrival = a then b
  task automatic run_sf(input logic [31:0] a[$], input logic [31:0] b[$]);
    logic [31:0] arr[$];
    int bc[16];
    arr = {a, b};
    foreach (bc[k]) bc[k] = 0;
    if (sf_in_tr == 0) add_exp({16'h0, tr_no[15:0]}, 1'b1, 1'b0);  // R5
    for (int bk = 0; bk < 16; bk++) begin                          // R2
      foreach (arr[k]) begin
        if (arr[k][27:24] == bk[3:0]) begin
          if (bc[bk] < DP) begin
            add_exp(arr[k], 1'b0, 1'b0); bc[bk]++; tr_hits++;
          end else tr_drops++;                                     // R8
        end
      end
    end
    sf_in_tr++;
    if (sf_in_tr == SF) begin                                      // R6 R10
      add_exp({(tr_drops != 0), tr_drops[14:0], tr_hits[15:0]}, 1'b0, 1'b1);
      tr_words = 0; tr_hits = 0; tr_drops = 0; sf_in_tr = 0; tr_no++;
    end
    fork
      drive(0, a);
      drive(1, b);
    join
  endtask

  task automatic cmp(input logic lk, input logic [31:0] d, input logic hd, input logic tl);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      failures++;
      $display("FAIL R2 unexpected word on link %0d: got %h expected none", lk, d);
    end else begin
      e = q.pop_front();
      if (e.d !== d || e.hd !== hd || e.tl !== tl || e.lk !== lk) begin
        failures++;
        $display("FAIL %s link/head/tail/data got %0d/%0d/%0d/%h expected %0d/%0d/%0d/%h",
                 e.hd ? "R5 R7" : (e.tl ? "R6 R8 R10" : "R2 R7"),
                 lk, hd, tl, d, e.lk, e.hd, e.tl, e.d);
      end
    end
  endtask

  // monitor: drives link readies, samples away from the rising edge
  always @(negedge clk) begin
    if (mon_on) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      o0_ready = lf[0] | lf[2];
      o1_ready = lf[1] | lf[3];
      #2;
      if (o0_valid && o0_ready) cmp(1'b0, o0_data, o0_head, o0_tail);
      if (o1_valid && o1_ready) cmp(1'b1, o1_data, o1_head, o1_tail);
      if (iv[0] && iv[1]) begin
        checks++;
        if (in_ready[1]) begin  // R3: stream 0 has priority
          failures++;
          $display("FAIL R3 in_ready[1] got 1 expected 0 while stream 0 valid");
        end
      end
      if (|in_ready) begin
        checks++;
        if (o0_valid || o1_valid) begin  // R4
          failures++;
          $display("FAIL R4 output valid got 1 expected 0 while inputs accepted");
        end
      end
    end
  end

  initial begin : watchdog
    for (int c = 0; c < 60000; c++) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    iv = '0; ieos = '0; idat0 = '0; idat1 = '0; o0_ready = 1'b0; o1_ready = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    checks++;
    if (o0_valid || o1_valid || in_ready != '0) begin  // R1
      failures++;
      $display("FAIL R1 valid0/valid1/ready got %0d/%0d/%b expected 0/0/00",
               o0_valid, o1_valid, in_ready);
    end
    mon_on = 1'b1;
    // train 0
    run_sf('{hw(8'h03,4'h1,20'h00A11), hw(8'h01,4'h1,20'h00B22), hw(8'h07,4'h1,20'h00C33)},
           '{hw(8'h01,4'h2,20'h00D44), hw(8'h00,4'h2,20'h00E55)});          // R2 R3
    run_sf('{}, '{});                                                        // empty slice
    run_sf('{hw(8'h25,4'h1,20'h1), hw(8'h25,4'h1,20'h2), hw(8'h25,4'h1,20'h3),
             hw(8'h25,4'h1,20'h4), hw(8'h25,4'h1,20'h5), hw(8'h25,4'h1,20'h6)},
           '{hw(8'h2F,4'h2,20'hFFFFF)});                                     // R8 overflow
    run_sf('{}, '{hw(8'h32,4'h3,20'h12345)});
    // train 1: counts restart (R10), header number 1 (R5)
    run_sf('{hw(8'h4A,4'h1,20'h0AAAA), hw(8'h40,4'h1,20'h0BBBB)},
           '{hw(8'h4F,4'h2,20'h0CCCC)});                                     // buckets 0/10/15
    run_sf('{hw(8'h5F,4'h1,20'h1), hw(8'h50,4'h1,20'h2)},
           '{hw(8'h50,4'h2,20'h3), hw(8'h58,4'h2,20'h4), hw(8'h5F,4'h2,20'h5)});
    run_sf('{hw(8'h66,4'h1,20'h7)}, '{});
    run_sf('{}, '{hw(8'h7C,4'h2,20'h9), hw(8'h71,4'h2,20'h8)});
    while (q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    #2;
    checks++;
    if (o0_valid || o1_valid) begin  // R7: idle after trailer
      failures++;
      $display("FAIL R7 idle valid0/valid1 got %0d/%0d expected 0/0", o0_valid, o1_valid);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule